// File: doc/BRIEF.md
# SPI Serial Memory Command Front-End

This block is the slave-side command front-end of a small serial nonvolatile memory. The raw serial pins are brought into the system clock domain through synchronizers, and each SCK edge becomes a one-cycle event. A sequencer then takes in an 8-bit command code, an optional 16-bit address and data bytes, most significant bit first. Six commands are recognised. Array reads and status reads stream bytes back on a serial output that has its own output-enable. A hold input pauses the transfer at the exact bit where it stopped.

Write traffic leaves the block as single-cycle valid strobes. These go to a neighbouring protection/status unit and page buffer. Each received write byte comes with its page-wrapped address. Write-enable set, write-enable clear, status writes and write commits are issued only when chip select rises at a legal point. The memory array sits outside the block and is read through a combinational address/data pair. The system clock must run at least four times faster than SCK.

Top module: `spi_mem_frontend`

## Requirements
- R1: Command codes are shifted in MSB first on rising SCK. The codes are 0x06 set write enable, 0x04 clear write enable, 0x05 read status, 0x01 write status, 0x03 read array and 0x02 write array.
- R2: After 0x03, a 16-bit address follows and only its low 12 bits are used. Array bytes then leave on so_o MSB first. Each bit changes after a falling SCK, and the address advances by one after each byte.
- R3: The read address wraps from 0xFFF to 0x000, and the read continues until chip select rises.
- R4: After 0x05, so_o streams the byte on status_i. It is sampled again at the start of every byte, whatever write activity is under way.
- R5: wren_o (for 0x06) or wrdi_o (for 0x04) pulses only when chip select rises directly after the eighth command bit. One further SCK rising edge cancels it.
- R6: After 0x02 and its address, each completed data byte pulses wr_byte_valid_o with wr_data_o and wr_addr_o. The address advances only within its 32-byte page, so the low 5 bits wrap.
- R7: wr_commit_o pulses when chip select rises on a byte boundary after at least one write data byte, and at no other time.
- R8: After 0x01, sr_wr_valid_o pulses with the received byte on sr_wr_data_o only when chip select rises directly after the eighth data bit.
- R9: Holding hold_ni low while SCK is low freezes the sequence and drops so_oe_o. SCK edges during the hold are ignored. Releasing it while SCK is low resumes at the same bit.
- R10: so_oe_o is low whenever chip select is high and after reset. A falling chip select is needed before any command is accepted after reset.
- R11: A chip select rise aborts a partial command or address and returns to idle. Unknown command codes are ignored, and so_o stays disabled until deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock (modes 0 and 3) |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause request, active low |
| status_i | input | 8 | Status byte returned by the read-status command |
| mem_rdata_i | input | 8 | Array byte at mem_addr_o |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for so_o |
| mem_addr_o | output | 12 | Array read address |
| wren_o | output | 1 | Set-write-enable strobe |
| wrdi_o | output | 1 | Clear-write-enable strobe |
| sr_wr_valid_o | output | 1 | Status write strobe |
| sr_wr_data_o | output | 8 | Status write byte |
| wr_byte_valid_o | output | 1 | Write data byte strobe |
| wr_addr_o | output | 12 | Address of the write byte |
| wr_data_o | output | 8 | Write data byte |
| wr_commit_o | output | 1 | Write commit strobe |

## Verification
Every pin passes two synchronizer flops and one edge register, so so_o moves three system cycles after a falling SCK. The bench samples it just before the next rising SCK, eight cycles after the fall. Each strobe appears three cycles after the rising chip select or SCK edge that completes it. The bench queues the expected strobe before driving that edge, and a monitor compares every strobe against the queue on falling system clocks. The bench holds chip select high for twelve cycles after every deselect, so each pending strobe arrives before the next command.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  typedef enum logic [3:0] {
    ST_OFF, ST_OP, ST_ADDR, ST_CMD, ST_SRW, ST_SRDONE,
    ST_WR, ST_RD, ST_RDSR, ST_SKIP
  } fe_state_e;

  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_WDIS = 8'h04;
  localparam logic [7:0] OP_STRD = 8'h05;
  localparam logic [7:0] OP_STWR = 8'h01;
  localparam logic [7:0] OP_RD   = 8'h03;
  localparam logic [7:0] OP_WR   = 8'h02;
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st[s] <= RST_VAL;
    end else begin
      st[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/spi_fe_seq.sv
module spi_fe_seq
  import spi_fe_pkg::*;
#(
  parameter int AW = 12,
  parameter int PW = 5,
  parameter int FIELD_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_rise_i,
  input  logic          si_i,
  input  logic          cs_fall_i,
  input  logic          cs_rise_i,
  output logic          tx_en_o,
  output logic          rd_status_o,
  output logic          rd_start_o,
  output logic [AW-1:0] rd_start_addr_o,
  output logic          wren_o,
  output logic          wrdi_o,
  output logic          sr_wr_valid_o,
  output logic [7:0]    sr_wr_data_o,
  output logic          wr_byte_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          wr_commit_o
);
  localparam int BCW = $clog2(FIELD_W);

  fe_state_e          st;
  logic [7:0]         sh;
  logic [FIELD_W-1:0] ash;
  logic [BCW-1:0]     bcnt;
  logic               wen_pend, rd_pend, wr_any;
  logic [AW-1:0]      wa;

  logic [7:0]         in_byte;
  logic [FIELD_W-1:0] in_addr;
  logic               byte_end;
  assign in_byte  = {sh[6:0], si_i};
  assign in_addr  = {ash[FIELD_W-2:0], si_i};
  assign byte_end = (bcnt[2:0] == 3'd7);
  assign tx_en_o  = (st == ST_RD) || (st == ST_RDSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_OFF;
      sh <= '0;
      ash <= '0;
      bcnt <= '0;
      wen_pend <= 1'b0;
      rd_pend <= 1'b0;
      wr_any <= 1'b0;
      wa <= '0;
      rd_status_o <= 1'b0;
      rd_start_o <= 1'b0;
      rd_start_addr_o <= '0;
      wren_o <= 1'b0;
      wrdi_o <= 1'b0;
      sr_wr_valid_o <= 1'b0;
      sr_wr_data_o <= '0;
      wr_byte_valid_o <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wr_commit_o <= 1'b0;
    end else begin
      wren_o <= 1'b0;
      wrdi_o <= 1'b0;
      sr_wr_valid_o <= 1'b0;
      wr_byte_valid_o <= 1'b0;
      wr_commit_o <= 1'b0;
      rd_start_o <= 1'b0;
      if (cs_rise_i) begin
        case (st)
          ST_CMD:    if (wen_pend) wren_o <= 1'b1; else wrdi_o <= 1'b1;
          ST_SRDONE: sr_wr_valid_o <= 1'b1;
          ST_WR:     if (wr_any && bcnt == '0) wr_commit_o <= 1'b1;
          default: ;
        endcase
        st <= ST_OFF;
      end else if (cs_fall_i) begin
        st <= ST_OP;
        bcnt <= '0;
        wr_any <= 1'b0;
      end else if (sck_rise_i) begin
        case (st)
          ST_OP: begin
            sh <= in_byte;
            bcnt <= bcnt + 1'b1;
            if (byte_end) begin
              bcnt <= '0;
              case (in_byte)
                OP_WEN:  begin st <= ST_CMD; wen_pend <= 1'b1; end
                OP_WDIS: begin st <= ST_CMD; wen_pend <= 1'b0; end
                OP_STRD: begin st <= ST_RDSR; rd_start_o <= 1'b1; rd_status_o <= 1'b1; end
                OP_RD:   begin st <= ST_ADDR; rd_pend <= 1'b1; end
                OP_WR:   begin st <= ST_ADDR; rd_pend <= 1'b0; end
                OP_STWR: st <= ST_SRW;
                default: st <= ST_SKIP;
              endcase
            end
          end
          ST_ADDR: begin
            ash <= in_addr;
            bcnt <= bcnt + 1'b1;
            if (bcnt == BCW'(FIELD_W - 1)) begin
              bcnt <= '0;
              if (rd_pend) begin
                st <= ST_RD;
                rd_start_o <= 1'b1;
                rd_status_o <= 1'b0;
                rd_start_addr_o <= in_addr[AW-1:0];
              end else begin
                st <= ST_WR;
                wa <= in_addr[AW-1:0];
              end
            end
          end
          ST_SRW: begin
            sh <= in_byte;
            bcnt <= bcnt + 1'b1;
            if (byte_end) begin
              bcnt <= '0;
              sr_wr_data_o <= in_byte;
              st <= ST_SRDONE;
            end
          end
          ST_WR: begin
            sh <= in_byte;
            bcnt <= bcnt + 1'b1;
            if (byte_end) begin
              bcnt <= '0;
              wr_byte_valid_o <= 1'b1;
              wr_addr_o <= wa;
              wr_data_o <= in_byte;
              wa <= {wa[AW-1:PW], wa[PW-1:0] + 1'b1};
              wr_any <= 1'b1;
            end
          end
          ST_CMD, ST_SRDONE: st <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end

  p_one_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wren_o, wrdi_o, sr_wr_valid_o, wr_commit_o, wr_byte_valid_o}));
  p_cmd_at_deselect_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wren_o || wrdi_o || sr_wr_valid_o) |-> $past(cs_rise_i));
  p_commit_from_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |-> $past(st == ST_WR) && st == ST_OFF);
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
  parameter int AW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          status_sel_i,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          fall_i,
  input  logic          hold_i,
  input  logic [7:0]    status_i,
  input  logic [7:0]    mem_rdata_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          so_o,
  output logic          live_o
);
  logic [7:0]    osr;
  logic [2:0]    ob;
  logic [AW-1:0] ra;
  logic          live;

  // a new byte is fetched on the first falling SCK of each byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osr <= '0;
      ob <= '0;
      ra <= '0;
      live <= 1'b0;
    end else if (!en_i) begin
      live <= 1'b0;
    end else if (start_i) begin
      ra <= start_addr_i;
      ob <= '0;
      live <= 1'b0;
    end else if (fall_i) begin
      ob <= ob + 1'b1;
      live <= 1'b1;
      if (ob == '0) begin
        osr <= status_sel_i ? status_i : mem_rdata_i;
        if (!status_sel_i) ra <= ra + 1'b1;
      end else begin
        osr <= {osr[6:0], 1'b0};
      end
    end
  end

  assign mem_addr_o = ra;
  assign so_o = live ? osr[7] : 1'b0;
  assign live_o = live;

  p_hold_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(osr) && $stable(ob));
  p_quiet_when_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !live);
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
  import spi_fe_pkg::*;
#(
  parameter int AW = 12,
  parameter int PW = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sck_i,
  input  logic          cs_ni,
  input  logic          si_i,
  input  logic          hold_ni,
  input  logic [7:0]    status_i,
  input  logic [7:0]    mem_rdata_i,
  output logic          so_o,
  output logic          so_oe_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          wren_o,
  output logic          wrdi_o,
  output logic          sr_wr_valid_o,
  output logic [7:0]    sr_wr_data_o,
  output logic          wr_byte_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          wr_commit_o
);
  localparam int NPIN = 4;
  // cs resets low so a select already low at reset never looks like a fall
  localparam logic [NPIN-1:0] PIN_RST = 4'b1000;

  logic [NPIN-1:0] pins_s;
  logic s_sck, s_cs, s_si, s_hold;
  logic sck_q, cs_q, hold_act;
  logic bus_live, sck_rise, sck_fall, cs_fall, cs_rise;
  logic tx_en, rd_status, rd_start, tx_live;
  logic [AW-1:0] rd_start_addr;

  spi_fe_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({hold_ni, si_i, cs_ni, sck_i}),
    .q_o   (pins_s)
  );
  assign {s_hold, s_si, s_cs, s_sck} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q <= 1'b0;
      hold_act <= 1'b0;
    end else begin
      sck_q <= s_sck;
      cs_q <= s_cs;
      if (s_cs) hold_act <= 1'b0;
      else if (!s_sck) hold_act <= ~s_hold;
    end
  end

  assign bus_live = ~s_cs & ~hold_act;
  assign sck_rise = bus_live & s_sck & ~sck_q;
  assign sck_fall = bus_live & ~s_sck & sck_q;
  assign cs_fall  = cs_q & ~s_cs;
  assign cs_rise  = ~cs_q & s_cs;

  spi_fe_seq #(.AW(AW), .PW(PW), .FIELD_W(16)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sck_rise_i     (sck_rise),
    .si_i           (s_si),
    .cs_fall_i      (cs_fall),
    .cs_rise_i      (cs_rise),
    .tx_en_o        (tx_en),
    .rd_status_o    (rd_status),
    .rd_start_o     (rd_start),
    .rd_start_addr_o(rd_start_addr),
    .wren_o         (wren_o),
    .wrdi_o         (wrdi_o),
    .sr_wr_valid_o  (sr_wr_valid_o),
    .sr_wr_data_o   (sr_wr_data_o),
    .wr_byte_valid_o(wr_byte_valid_o),
    .wr_addr_o      (wr_addr_o),
    .wr_data_o      (wr_data_o),
    .wr_commit_o    (wr_commit_o)
  );

  spi_fe_tx #(.AW(AW)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (tx_en),
    .status_sel_i(rd_status),
    .start_i     (rd_start),
    .start_addr_i(rd_start_addr),
    .fall_i      (sck_fall),
    .hold_i      (hold_act),
    .status_i    (status_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .so_o        (so_o),
    .live_o      (tx_live)
  );

  assign so_oe_o = tx_live & ~hold_act & ~s_cs;
endmodule

// File: tb/spi_mem_frontend_test.sv
module spi_mem_frontend_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic [7:0] status = 8'h00;
  logic [7:0] mem_rdata;
  logic so, so_oe, wren, wrdi, sr_v, wb_v, commit;
  logic [11:0] mem_addr, wr_addr;
  logic [7:0] sr_d, wr_d;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_f(logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
  endfunction
  assign mem_rdata = mem_f(mem_addr);

  spi_mem_frontend uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .si_i(si),
    .hold_ni(hold_n), .status_i(status), .mem_rdata_i(mem_rdata),
    .so_o(so), .so_oe_o(so_oe), .mem_addr_o(mem_addr),
    .wren_o(wren), .wrdi_o(wrdi), .sr_wr_valid_o(sr_v), .sr_wr_data_o(sr_d),
    .wr_byte_valid_o(wb_v), .wr_addr_o(wr_addr), .wr_data_o(wr_d),
    .wr_commit_o(commit)
  );

  typedef struct {
    int kind;
    logic [11:0] a;
    logic [7:0] d;
    string req;
  } exp_t;
  exp_t evq[$];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // kinds: 1 set-enable, 2 clear-enable, 3 status write, 4 write byte, 5 commit
  task automatic expect_ev(int k, logic [11:0] a, logic [7:0] d, string req);
    exp_t e;
    e.kind = k; e.a = a; e.d = d; e.req = req;
    evq.push_back(e);
  endtask

  task automatic got(int k, logic [11:0] a, logic [7:0] d);
    exp_t e;
    checks++;
    if (evq.size() == 0) begin
      errors++;
      $display("FAIL R11 spurious strobe: actual kind %0d addr %0h data %0h expected none", k, a, d);
    end else begin
      e = evq.pop_front();
      if (e.kind != k || e.a != a || e.d != d) begin
        errors++;
        $display("FAIL %s strobe: actual %0d/%0h/%0h expected %0d/%0h/%0h",
                 e.req, k, a, d, e.kind, e.a, e.d);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wren)   got(1, 12'h0, 8'h0);
      if (wrdi)   got(2, 12'h0, 8'h0);
      if (sr_v)   got(3, 12'h0, sr_d);
      if (wb_v)   got(4, wr_addr, wr_d);
      if (commit) got(5, 12'h0, 8'h0);
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    si = b;
    wait_n(HALF);
    r = so;
    sck = 1'b1;
    wait_n(HALF);
    sck = 1'b0;
  endtask

  task automatic do_hold();
    hold_n = 1'b0;
    wait_n(8);
    chk(so_oe == 1'b0, "R9 hold disables so", so_oe, 0);
    repeat (2) begin
      sck = 1'b1; wait_n(HALF);
      sck = 1'b0; wait_n(HALF);
    end
    hold_n = 1'b1;
    wait_n(8);
  endtask

  task automatic byte_x(input logic [7:0] t, output logic [7:0] r, input int hold_bit = -1);
    logic rb;
    for (int i = 7; i >= 0; i--) begin
      if (i == hold_bit) do_hold();
      bit_x(t[i], rb);
      r[i] = rb;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_n(8);
  endtask

  task automatic desel();
    wait_n(4);
    cs_n = 1'b1;
    wait_n(12);
  endtask

  initial begin
    logic [7:0] r;
    logic rb;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);
    chk(so_oe == 1'b0, "R10 reset so_oe", so_oe, 0);

    // R10: select low since reset, no falling edge seen: command ignored
    byte_x(8'h06, r);
    desel();

    // R1 R5: set and clear write enable
    sel(); byte_x(8'h06, r); expect_ev(1, 0, 0, "R5 set enable"); desel();
    sel(); byte_x(8'h04, r); expect_ev(2, 0, 0, "R1 clear enable"); desel();

    // R5: one extra clock cancels
    sel(); byte_x(8'h06, r); bit_x(1'b0, rb); desel();

    // R2 R3: read from 0xAFFE uses 0xFFE and wraps
    sel();
    byte_x(8'h03, r); byte_x(8'hAF, r); byte_x(8'hFE, r);
    byte_x(8'h00, r);
    chk(r == mem_f(12'hFFE), "R2 first read byte", r, mem_f(12'hFFE));
    chk(so_oe == 1'b1, "R2 so enabled during read", so_oe, 1);
    byte_x(8'h00, r);
    chk(r == mem_f(12'hFFF), "R2 second read byte", r, mem_f(12'hFFF));
    byte_x(8'h00, r);
    chk(r == mem_f(12'h000), "R3 wrapped read byte", r, mem_f(12'h000));
    desel();
    chk(so_oe == 1'b0, "R10 so off after deselect", so_oe, 0);

    // R4: status stream, sampled per byte
    status = 8'hA5;
    sel(); byte_x(8'h05, r);
    byte_x(8'h00, r);
    chk(r == 8'hA5, "R4 status byte", r, 8'hA5);
    status = 8'h3C;
    byte_x(8'h00, r);
    chk(r == 8'h3C, "R4 status resampled", r, 8'h3C);
    desel();

    // R6 R7: page write wraps low 5 bits, commit on boundary
    sel(); byte_x(8'h02, r); byte_x(8'h01, r); byte_x(8'h3E, r);
    expect_ev(4, 12'h13E, 8'h11, "R6 write byte 0");
    byte_x(8'h11, r);
    expect_ev(4, 12'h13F, 8'h22, "R6 write byte 1");
    byte_x(8'h22, r);
    expect_ev(4, 12'h120, 8'h33, "R6 page wrap");
    byte_x(8'h33, r);
    expect_ev(5, 0, 0, "R7 commit");
    desel();

    // R7: deselect mid-byte gives no commit
    sel(); byte_x(8'h02, r); byte_x(8'h00, r); byte_x(8'h40, r);
    expect_ev(4, 12'h040, 8'h5A, "R6 single byte");
    byte_x(8'h5A, r);
    repeat (3) bit_x(1'b1, rb);
    desel();

    // R8: status write and its cancellation
    sel(); byte_x(8'h01, r); byte_x(8'h8C, r);
    expect_ev(3, 0, 8'h8C, "R8 status write");
    desel();
    sel(); byte_x(8'h01, r); byte_x(8'h8C, r); bit_x(1'b0, rb); desel();

    // R11: unknown code ignored, partial command aborted
    sel(); byte_x(8'hFF, r); byte_x(8'h03, r);
    chk(so_oe == 1'b0, "R11 unknown code keeps so off", so_oe, 0);
    desel();
    sel(); repeat (5) bit_x(1'b0, rb); desel();
    sel(); byte_x(8'h06, r); expect_ev(1, 0, 0, "R11 clean restart"); desel();

    // R9: hold mid-byte during a read
    sel(); byte_x(8'h03, r); byte_x(8'h00, r); byte_x(8'h10, r);
    byte_x(8'h00, r, 4);
    chk(r == mem_f(12'h010), "R9 byte across hold", r, mem_f(12'h010));
    byte_x(8'h00, r);
    chk(r == mem_f(12'h011), "R9 byte after hold", r, mem_f(12'h011));
    desel();

    wait_n(10);
    chk(evq.size() == 0, "R5 R7 R8 missing strobes", evq.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule